// File: doc/BRIEF.md
# Programmable-Priority Shared Memory Arbiter

This block decides which of four requesters may use a single shared data-memory port in a given cycle. The requesters are a processor, a USB engine, a DMA engine and a debug port. Each has a request input and receives a grant and a stall output. The grant is worked out combinationally from the requests in the current cycle. A requester that loses is stalled and is served in a later cycle.

The priority among the requesters is fixed at any moment but can be changed through a 16-bit control register. Bit 3 moves the USB engine above the processor and bit 5 moves the DMA engine above it. Requesters that are moved up keep their base order among themselves, and so do the requesters that stay below the processor. The debug port always has the lowest priority. Only four register values are accepted, and the register drops any write of another value.

Once a requester holds the bus, it keeps its grant for as long as it keeps its request asserted. A new choice is made only when the bus is free, so a change of priority never cuts off an access that is in progress.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset the control register reads 0x0000, and with no requests no grant or stall is asserted.
- R2: At most one grant is asserted in any cycle, and only a requester that is asserting its request can receive it.
- R3: When at least one request is asserted, some grant is asserted in that same cycle. Every requester that asserts its request without being granted has its stall asserted, and no other requester is stalled.
- R4: With register value 0x0000 the priority on a free bus is processor, then USB, then DMA, then debug. Bit index 0 is the processor, 1 is USB, 2 is DMA and 3 is debug.
- R5: With register value 0x0008 (bit 3 set, USB promoted) the priority is USB, then processor, then DMA, then debug.
- R6: With register value 0x0020 (bit 5 set, DMA promoted) the priority is DMA, then processor, then USB, then debug.
- R7: With register value 0x0028 (both bits set) the priority is USB, then DMA, then processor, then debug.
- R8: A write whose value is not one of 0x0000, 0x0008, 0x0020 or 0x0028 leaves the register and the arbitration order unchanged.
- R9: A granted requester keeps its grant in the following cycles for as long as its request stays asserted, whatever other requests arrive. When it drops its request, the choice among the remaining requests is made in that same cycle.
- R10: A legal write is loaded on the clock edge that ends the write cycle. The choice made in the write cycle uses the old order, and the first choice after that edge uses the new order.
- R11: In every legal setting, the debug port wins a choice on a free bus only when it is the only requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 4 | Requests: bit 0 processor, 1 USB, 2 DMA, 3 debug |
| grant | output | 4 | One-hot grant, same bit order as req |
| stall | output | 4 | Requester is waiting, same bit order as req |
| cfg_we | input | 1 | Write strobe for the priority register |
| cfg_wdata | input | 16 | Value to write to the priority register |
| cfg_rdata | output | 16 | Current value of the priority register |

## Verification
Two events can fall in the same cycle: a priority write and a choice on a free bus. The same goes for a priority write and an access that is in progress. To provoke the first, the bench writes the register while the processor and USB request together. It then checks that the processor wins in the write cycle, and that USB wins once the bus is free again after the edge. To provoke the second, the bench promotes a requester while another one holds the bus. It checks that the current holder keeps its grant until it releases, and that the new order decides the next winner.

// File: rtl/pba_pkg.sv
package pba_pkg;
  localparam int NREQ = 4;
  localparam int IDW  = 2;

  typedef logic [IDW-1:0] mid_t;
  typedef logic [NREQ-1:0][IDW-1:0] rank_t;

  localparam mid_t MID_CPU = 2'd0;
  localparam mid_t MID_USB = 2'd1;
  localparam mid_t MID_DMA = 2'd2;
  localparam mid_t MID_DBG = 2'd3;

  // A value is accepted when it sets no bit outside the promotion mask.
  function automatic logic cfg_is_legal(input logic [15:0] v, input logic [15:0] mask);
    return (v & ~mask) == 16'h0000;
  endfunction

  // Slot 0 is the highest priority. Promoted peripherals come first, in base order.
  function automatic rank_t build_rank(input logic up_usb, input logic up_dma);
    rank_t r;
    int k;
    r = '0;
    k = 0;
    if (up_usb) begin r[k] = MID_USB; k++; end
    if (up_dma) begin r[k] = MID_DMA; k++; end
    r[k] = MID_CPU; k++;
    if (!up_usb) begin r[k] = MID_USB; k++; end
    if (!up_dma) begin r[k] = MID_DMA; k++; end
    r[k] = MID_DBG;
    return r;
  endfunction
endpackage

// File: rtl/pba_prio_reg.sv
module pba_prio_reg #(
  parameter int CFG_W   = 16,
  parameter int USB_BIT = 3,
  parameter int DMA_BIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q,
  output logic             wr_accept,
  output logic             promote_usb,
  output logic             promote_dma
);
  import pba_pkg::*;

  localparam logic [15:0] PROMO_MASK = 16'((1 << USB_BIT) | (1 << DMA_BIT));

  assign wr_accept = we && cfg_is_legal(16'(wdata), PROMO_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (wr_accept) q <= wdata;
  end

  assign promote_usb = q[USB_BIT];
  assign promote_dma = q[DMA_BIT];
endmodule

// File: rtl/pba_rank_map.sv
module pba_rank_map (
  input  logic            promote_usb,
  input  logic            promote_dma,
  output pba_pkg::rank_t  rank
);
  import pba_pkg::*;
  always_comb rank = build_rank(promote_usb, promote_dma);
endmodule

// File: rtl/pba_pick.sv
module pba_pick (
  input  logic [pba_pkg::NREQ-1:0] req,
  input  pba_pkg::rank_t           rank,
  output logic [pba_pkg::NREQ-1:0] win
);
  import pba_pkg::*;
  // Walk from lowest to highest slot; a higher slot overrides.
  always_comb begin
    win = '0;
    for (int s = NREQ - 1; s >= 0; s--) begin
      if (req[rank[s]]) begin
        win = '0;
        win[rank[s]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int CFG_W   = 16,
  parameter int USB_BIT = 3,
  parameter int DMA_BIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       req,
  output logic [3:0]       grant,
  output logic [3:0]       stall,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata
);
  import pba_pkg::*;

  logic           promote_usb, promote_dma, wr_accept;
  rank_t          rank;
  logic [NREQ-1:0] win, owner_q, held;
  logic           bus_busy, decide;

  pba_prio_reg #(.CFG_W(CFG_W), .USB_BIT(USB_BIT), .DMA_BIT(DMA_BIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_rdata),
    .wr_accept(wr_accept), .promote_usb(promote_usb), .promote_dma(promote_dma));

  pba_rank_map u_map (.promote_usb(promote_usb), .promote_dma(promote_dma), .rank(rank));

  pba_pick u_pick (.req(req), .rank(rank), .win(win));

  // Current holder keeps the bus while it still requests.
  assign held     = owner_q & req;
  assign bus_busy = |held;
  assign decide   = !bus_busy && (|req);
  assign grant    = bus_busy ? held : win;
  assign stall    = req & ~grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= '0;
    else        owner_q <= grant;
  end
endmodule

// File: rtl/pba_checker.sv
module pba_checker #(
  parameter int CFG_W   = 16,
  parameter int USB_BIT = 3,
  parameter int DMA_BIT = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       req,
  input logic [3:0]       grant,
  input logic [3:0]       stall,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             decide
);
  localparam logic [CFG_W-1:0] OK_BITS = CFG_W'((1 << USB_BIT) | (1 << DMA_BIT));
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0; else past_ok <= 1'b1;

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  p_grant_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~req) == 4'b0);
  p_no_idle_r3: assert property (@(posedge clk) disable iff (!rst_n) (|req) |-> (|grant));
  p_stall_waiting_r3: assert property (@(posedge clk) disable iff (!rst_n) (stall != 4'b0) |-> (grant != 4'b0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ((req & $past(grant)) != 4'b0)) |-> (grant == $past(grant)));
  p_reserved_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && ((cfg_wdata & ~OK_BITS) != '0)) |=> $stable(cfg_rdata));
  p_reg_legal_r8: assert property (@(posedge clk) disable iff (!rst_n) (cfg_rdata & ~OK_BITS) == '0);
  p_debug_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && grant[3]) |-> (req[2:0] == 3'b0));
endmodule

bind prio_bus_arbiter pba_checker #(.CFG_W(CFG_W), .USB_BIT(USB_BIT), .DMA_BIT(DMA_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .stall(stall),
  .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .decide(decide));

// File: tb/prio_bus_arbiter_tb.sv
module prio_bus_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] req = 4'b0;
  logic [3:0] grant, stall;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = 16'h0;
  logic [15:0] cfg_rdata;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_bus_arbiter u_dut (.clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .stall(stall),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent order tables: list of requester indices, highest first.
  function automatic logic [3:0] model_win(input logic [15:0] cfg, input logic [3:0] r);
    int ord[4];
    case (cfg)
      16'h0008: ord = '{1, 0, 2, 3};
      16'h0020: ord = '{2, 0, 1, 3};
      16'h0028: ord = '{1, 2, 0, 3};
      default:  ord = '{0, 1, 2, 3};
    endcase
    for (int i = 0; i < 4; i++) if (r[ord[i]]) return 4'(1 << ord[i]);
    return 4'b0;
  endfunction

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check("R1 cfg", cfg_rdata, 16'h0);
    check("R1 grant", {12'b0, grant}, 16'h0);
    check("R1 stall", {12'b0, stall}, 16'h0);
  endtask

  task automatic t_order(input logic [15:0] cfg, input string tag);
    write_cfg(cfg);
    check({tag, " cfg"}, cfg_rdata, cfg);
    for (int p = 1; p < 16; p++) begin
      @(negedge clk); req = 4'(p); #1;
      check({tag, " grant"}, {12'b0, grant}, {12'b0, model_win(cfg, 4'(p))});
      check("R3 stall", {12'b0, stall}, {12'b0, 4'(p) & ~model_win(cfg, 4'(p))});
      check("R2 onehot", 16'($countones(grant)), 16'd1);
      if (p == 8) check("R11 debug alone", {12'b0, grant}, 16'h8);
      else check("R11 debug loses", {15'b0, grant[3]}, 16'h0);
      @(negedge clk); req = 4'b0;
    end
  endtask

  task automatic t_reserved();
    write_cfg(16'h0008);
    write_cfg(16'h0010);
    check("R8 0x0010", cfg_rdata, 16'h0008);
    write_cfg(16'hFFFF);
    check("R8 0xFFFF", cfg_rdata, 16'h0008);
    write_cfg(16'h0009);
    check("R8 0x0009", cfg_rdata, 16'h0008);
    @(negedge clk); req = 4'b0011; #1;
    check("R8 order kept", {12'b0, grant}, 16'h2);
    @(negedge clk); req = 4'b0;
  endtask

  task automatic t_hold();
    write_cfg(16'h0000);
    @(negedge clk); req = 4'b1000; #1;
    check("R9 dbg alone", {12'b0, grant}, 16'h8);
    @(negedge clk); req = 4'b1111; #1;
    check("R9 dbg held", {12'b0, grant}, 16'h8);
    check("R9 others stall", {12'b0, stall}, 16'h7);
    @(negedge clk); #1;
    check("R9 still held", {12'b0, grant}, 16'h8);
    @(negedge clk); req = 4'b0111; #1;
    check("R9 release same cycle", {12'b0, grant}, 16'h1);
    @(negedge clk); req = 4'b0;
    // priority change during an access
    @(negedge clk); req = 4'b0010; #1;
    check("R9 usb alone", {12'b0, grant}, 16'h2);
    @(negedge clk); req = 4'b0111; cfg_we = 1'b1; cfg_wdata = 16'h0020; #1;
    check("R9 usb kept", {12'b0, grant}, 16'h2);
    @(negedge clk); cfg_we = 1'b0; #1;
    check("R9 usb kept after write", {12'b0, grant}, 16'h2);
    @(negedge clk); req = 4'b0101; #1;
    check("R9 dma next", {12'b0, grant}, 16'h4);
    @(negedge clk); req = 4'b0;
  endtask

  task automatic t_timing();
    write_cfg(16'h0000);
    @(negedge clk); req = 4'b0011; cfg_we = 1'b1; cfg_wdata = 16'h0008; #1;
    check("R10 old order in write cycle", {12'b0, grant}, 16'h1);
    @(negedge clk); cfg_we = 1'b0; req = 4'b0; #1;
    check("R10 loaded", cfg_rdata, 16'h0008);
    @(negedge clk); req = 4'b0011; #1;
    check("R10 new order", {12'b0, grant}, 16'h2);
    @(negedge clk); req = 4'b0; #1;
    check("R3 idle stall", {12'b0, stall}, 16'h0);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_order(16'h0000, "R4");
    t_order(16'h0008, "R5");
    t_order(16'h0020, "R6");
    t_order(16'h0028, "R7");
    t_reserved();
    t_hold();
    t_timing();
    done = 1;
    report();
  end
endmodule